// File: doc/BRIEF.md
# Parallel-Bus DAC Front End

This block is the digital side of a 12-bit voltage-output converter that hangs on a parallel microprocessor bus. A bus master presents a 12-bit word with chip select and a register-select line held, then releases an active-low write strobe. On the strobe's rising edge the word is steered into a holding latch (select low) or into a four-bit control register (select high). A separate active-low load input copies the holding latch into the DAC latch, whose contents drive the converter core. Holding the load input high therefore lets software stage a new code and commit it at a hardware-chosen instant.

All bus inputs are asynchronous. They pass through one shared synchronizer pipeline into the system clock domain, and the design is fully synchronous from there on. The control register is decoded into a settling-speed flag, a power-down flag and a two-flag reference choice. The analog core turns the code into an output of 2·Vref·code/4096, so code 0 gives 0 V and code 2048 gives Vref. A one-cycle pulse marks every change of the DAC latch.

Top module: `dacfe_top`

## Requirements
- R1: While reset is asserted, and after reset until the first write, the DAC code, the holding latch, the fast-settle flag, the power-down flag and both reference flags are all zero. The holding latch is observed by pulling the load input low, which must leave the code at 0.
- R2: A rising edge of the write strobe with chip select low and register-select 0 stores the 12-bit bus word in the holding latch.
- R3: A rising edge of the write strobe while chip select is high changes neither the holding latch nor the control register.
- R4: While the load input is high the DAC code does not change, even across writes. While it is low the DAC code takes the holding latch value.
- R5: A write with register-select 1 loads the control register from bus bits 3:0: bit 0 is fast settling (1 fast, 0 slow), bit 1 is power-down (1 down), and bits 3:2 are the reference choice. Bits 11:4 are ignored, and the holding latch is left untouched.
- R6: Reference choice 01 gives internal low reference (ref_internal=1, ref_high=0). Choice 10 gives internal high reference (ref_internal=1, ref_high=1). Choices 00 and 11 give an external reference (both flags 0).
- R7: Entering and leaving power-down leaves the DAC code unchanged.
- R8: When a holding-latch write is captured in the same cycle that the load input is seen low, the DAC latch takes the newly written word.
- R9: code_upd is high for exactly one cycle, in the cycle the DAC code takes a different value, and never otherwise. Reloading an equal value gives no pulse.
- R10: The word, register-select and chip select captured for a write are the values present while the strobe was still low. A bus change made at the same moment as the strobe rises does not reach the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_dat | input | 12 | Bus data word |
| bus_ctl_sel | input | 1 | Register select: 0 holding latch, 1 control register |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe, captured on its rising edge |
| load_n | input | 1 | Active-low load of the DAC latch from the holding latch |
| code_out | output | 12 | DAC latch contents driving the converter core |
| code_upd | output | 1 | One-cycle pulse when code_out changes |
| fast_settle | output | 1 | Fast settling mode selected |
| pwr_down | output | 1 | Power-down requested |
| ref_internal | output | 1 | Internal reference selected |
| ref_high | output | 1 | Internal reference at the high (2.048 V) level |

## Verification
The bench targets staged writes with the load input high, where a design that leaks writes straight to the DAC latch would move the output early. It also covers strobes with chip select high, which a careless design would still accept, and control writes with junk in the upper bits, which a sloppy decoder would copy into the holding latch. It drives a write while load is held low to confirm the transparent path, and changes the bus at the instant the strobe rises, where a design that samples late would latch the wrong word. It counts update pulses to catch designs that pulse on equal reloads or across power-down.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned CTL_W  = 4;

  typedef struct packed {
    logic [1:0] refsel;
    logic       pd;
    logic       fast;
  } ctl_t;

  localparam logic [1:0] REF_INT_LO = 2'b01;
  localparam logic [1:0] REF_INT_HI = 2'b10;

  function automatic logic is_internal(input logic [1:0] r);
    return (r == REF_INT_LO) || (r == REF_INT_HI);
  endfunction
endpackage

// File: rtl/dacfe_rst_sync.sv
module dacfe_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb chain_d = {chain_q[DEPTH-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[DEPTH-1];
endmodule

// File: rtl/dacfe_sync_pipe.sv
module dacfe_sync_pipe #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q_prev,
  output logic [W-1:0] q_last
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] stage_d;
    if (i == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_rest
      always_comb stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else        stage_q[i] <= stage_d;
    end
  end

  assign q_prev = stage_q[DEPTH-2];
  assign q_last = stage_q[DEPTH-1];
endmodule

// File: rtl/dacfe_capture.sv
module dacfe_capture
  import dacfe_pkg::*;
#(
  parameter int unsigned DW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          cs_n_s,
  input  logic          sel_s,
  input  logic [DW-1:0] dat_s,
  output logic          hold_we,
  output logic [DW-1:0] hold_q,
  output ctl_t          ctl_q
);
  logic          ctl_we;
  logic [DW-1:0] hold_d;
  ctl_t          ctl_d;

  always_comb begin
    hold_we = wr_rise && !cs_n_s && !sel_s;
    ctl_we  = wr_rise && !cs_n_s &&  sel_s;
    hold_d  = hold_we ? dat_s : hold_q;
    ctl_d   = ctl_we ? ctl_t'(dat_s[CTL_W-1:0]) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ctl_q  <= '0;
    end else begin
      hold_q <= hold_d;
      ctl_q  <= ctl_d;
    end
  end
endmodule

// File: rtl/dacfe_out_latch.sv
module dacfe_out_latch #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_act,
  input  logic          hold_we,
  input  logic [DW-1:0] hold_wd,
  input  logic [DW-1:0] hold_q,
  output logic [DW-1:0] dac_q,
  output logic          upd_q
);
  logic [DW-1:0] dac_d;
  logic          upd_d;

  always_comb begin
    dac_d = dac_q;
    if (ld_act) dac_d = hold_we ? hold_wd : hold_q;
    upd_d = (dac_d != dac_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      upd_q <= 1'b0;
    end else begin
      dac_q <= dac_d;
      upd_q <= upd_d;
    end
  end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int unsigned DW         = CODE_W,
  parameter int unsigned SYNC_DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_dat,
  input  logic          bus_ctl_sel,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic          load_n,
  output logic [DW-1:0] code_out,
  output logic          code_upd,
  output logic          fast_settle,
  output logic          pwr_down,
  output logic          ref_internal,
  output logic          ref_high
);
  localparam int unsigned SW     = DW + 4;
  localparam int unsigned I_LOAD = DW;
  localparam int unsigned I_WR   = DW + 1;
  localparam int unsigned I_SEL  = DW + 2;
  localparam int unsigned I_CS   = DW + 3;
  localparam logic [SW-1:0] IDLE = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic          rst_int_n;
  logic [SW-1:0] s_prev, s_last;
  logic          wr_rise, ld_act, hold_we;
  logic [DW-1:0] hold_q;
  ctl_t          ctl_q;

  dacfe_rst_sync #(.DEPTH(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  dacfe_sync_pipe #(.W(SW), .DEPTH(SYNC_DEPTH), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .din({bus_cs_n, bus_ctl_sel, bus_wr_n, load_n, bus_dat}),
    .q_prev(s_prev), .q_last(s_last)
  );

  // strobe seen high now, low one sample earlier; s_last holds that earlier bus
  assign wr_rise = s_prev[I_WR] && !s_last[I_WR];
  assign ld_act  = !s_prev[I_LOAD];

  dacfe_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .wr_rise(wr_rise),
    .cs_n_s(s_last[I_CS]), .sel_s(s_last[I_SEL]), .dat_s(s_last[DW-1:0]),
    .hold_we(hold_we), .hold_q(hold_q), .ctl_q(ctl_q)
  );

  dacfe_out_latch #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_int_n), .ld_act(ld_act), .hold_we(hold_we),
    .hold_wd(s_last[DW-1:0]), .hold_q(hold_q),
    .dac_q(code_out), .upd_q(code_upd)
  );

  always_comb begin
    fast_settle  = ctl_q.fast;
    pwr_down     = ctl_q.pd;
    ref_internal = is_internal(ctl_q.refsel);
    ref_high     = (ctl_q.refsel == REF_INT_HI);
  end
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_act,
  input logic [DW-1:0] code,
  input logic          upd,
  input logic          fast,
  input logic          pd,
  input logic          ref_int,
  input logic          ref_hi
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_vals_r1: assert (code == '0 && !upd && !fast && !pd && !ref_int && !ref_hi);
    end
  end

  p_no_change_unloaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_act |=> $stable(code));

  p_change_flags_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> upd);

  p_upd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  p_high_implies_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hi |-> ref_int);
endmodule

bind dacfe_top dacfe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .ld_act(ld_act), .code(code_out),
  .upd(code_upd), .fast(fast_settle), .pd(pwr_down),
  .ref_int(ref_internal), .ref_hi(ref_high)
);

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_dat;
  logic        bus_ctl_sel, bus_cs_n, bus_wr_n, load_n;
  logic [11:0] code_out;
  logic        code_upd, fast_settle, pwr_down, ref_internal, ref_high;

  int n_chk = 0;
  int n_bad = 0;
  int n_upd = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacfe_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_dat(bus_dat), .bus_ctl_sel(bus_ctl_sel),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .load_n(load_n),
    .code_out(code_out), .code_upd(code_upd), .fast_settle(fast_settle),
    .pwr_down(pwr_down), .ref_internal(ref_internal), .ref_high(ref_high)
  );

  always @(negedge clk) if (rst_n && code_upd) n_upd++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // late_dat differs from dat: driven at the moment the strobe rises
  task automatic bus_write(input bit sel, input logic [11:0] dat, input bit cs_n,
                           input bit late, input logic [11:0] late_dat);
    @(negedge clk);
    bus_ctl_sel = sel; bus_dat = dat; bus_cs_n = cs_n; bus_wr_n = 1'b0;
    idle(4);
    bus_wr_n = 1'b1;
    if (late) begin bus_dat = late_dat; bus_ctl_sel = ~sel; bus_cs_n = 1'b1; end
    idle(4);
    bus_cs_n = 1'b1;
    idle(2);
  endtask

  task automatic load_pulse();
    @(negedge clk); load_n = 1'b0;
    idle(4);
    load_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset();
    chk("R1 code", code_out, 0);
    chk("R1 flags", {fast_settle, pwr_down, ref_internal, ref_high}, 0);
    chk("R1 upd", code_upd, 0);
    load_pulse();
    chk("R1 holding zero", code_out, 0);
    chk("R9 no pulse on equal load", n_upd, 0);
  endtask

  task automatic t_staged();
    bus_write(1'b0, 12'h5A3, 1'b0, 1'b0, 12'h0);
    chk("R4 held while load high", code_out, 0);
    load_pulse();
    chk("R2 holding to code", code_out, 12'h5A3);
    chk("R9 one pulse", n_upd, 1);
    bus_write(1'b0, 12'h123, 1'b0, 1'b0, 12'h0);
    chk("R4 write not passed", code_out, 12'h5A3);
    load_pulse();
    chk("R2 second word", code_out, 12'h123);
    chk("R9 two pulses", n_upd, 2);
  endtask

  task automatic t_cs_high();
    bus_write(1'b0, 12'hFFF, 1'b1, 1'b0, 12'h0);
    bus_write(1'b1, 12'h00F, 1'b1, 1'b0, 12'h0);
    chk("R3 ctl untouched", {fast_settle, pwr_down, ref_internal, ref_high}, 0);
    load_pulse();
    chk("R3 holding untouched", code_out, 12'h123);
  endtask

  task automatic t_ctl();
    for (int r = 0; r < 4; r++) begin
      logic [11:0] w;
      bit ex_int, ex_hi;
      w = {8'hA5, 2'(r), 1'b0, 1'(r[0])};
      ex_int = (r == 1) || (r == 2);
      ex_hi  = (r == 2);
      bus_write(1'b1, w, 1'b0, 1'b0, 12'h0);
      chk("R5 fast bit", fast_settle, r[0]);
      chk("R5 pd bit", pwr_down, 0);
      chk("R6 ref flags", {ref_internal, ref_high}, {ex_int, ex_hi});
    end
    load_pulse();
    chk("R5 holding untouched by ctl", code_out, 12'h123);
  endtask

  task automatic t_pd();
    int base = n_upd;
    bus_write(1'b1, 12'hFF2, 1'b0, 1'b0, 12'h0);
    chk("R5 pd set", pwr_down, 1);
    chk("R7 code kept in pd", code_out, 12'h123);
    bus_write(1'b1, 12'h000, 1'b0, 1'b0, 12'h0);
    chk("R7 pd released", pwr_down, 0);
    chk("R7 code after pd", code_out, 12'h123);
    chk("R9 no pulse across pd", n_upd, base);
  endtask

  task automatic t_transparent();
    int base = n_upd;
    @(negedge clk); load_n = 1'b0; idle(4);
    bus_write(1'b0, 12'h7FF, 1'b0, 1'b0, 12'h0);
    chk("R8 follows write", code_out, 12'h7FF);
    bus_write(1'b0, 12'h800, 1'b0, 1'b0, 12'h0);
    chk("R8 follows second write", code_out, 12'h800);
    bus_write(1'b0, 12'h800, 1'b0, 1'b0, 12'h0);
    chk("R9 pulses only on change", n_upd, base + 2);
    load_n = 1'b1; idle(4);
  endtask

  task automatic t_late();
    bus_write(1'b0, 12'h3C6, 1'b0, 1'b1, 12'hC39);
    load_pulse();
    chk("R10 pre-edge word", code_out, 12'h3C6);
    chk("R10 ctl unaffected", {fast_settle, pwr_down, ref_internal, ref_high}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_dat = '0; bus_ctl_sel = 1'b0;
    bus_cs_n = 1'b1; bus_wr_n = 1'b1; load_n = 1'b1;
    idle(3);
    chk("R1 code in reset", code_out, 0);
    rst_n = 1'b1;
    idle(6);
    t_reset();
    t_staged();
    t_cs_high();
    t_ctl();
    t_pd();
    t_transparent();
    t_late();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule